// File: doc/BRIEF.md
# Predictability-Gated Conditional-Select Predictor

This block sits beside the issue stage and advises on conditional-select instructions (conditional move, set-on-condition). For each one it first decides whether the condition has been behaving predictably. Only when that estimate is confident does it tell the pipeline to speculate on a predicted outcome. Otherwise it tells the pipeline to hold the select until the real flags arrive. Hard-to-predict selects are therefore never speculated and never cause a restart.

One table, indexed by a fold of the instruction address, holds two saturating counters per entry. A 2-bit direction counter guesses the outcome. A 3-bit confidence counter measures how reliable that guess has been. The lookup port reads an entry and returns a registered verdict one cycle later. The update port trains the entry with the resolved outcome. It also raises a one-cycle restart pulse when a speculated guess turns out wrong, so that all younger work is discarded and execution resumes at that select.

Top module: `csel_gate_pred`

## Requirements
- R1: After reset every entry holds direction counter 1 and confidence 0. A lookup then returns `pred_spec`=0 and `pred_taken`=0, and `pred_valid` and `restart` are 0 straight after reset.
- R2: `pred_valid` is 1 in exactly the cycle after a cycle with `lk_valid`=1. When `pred_valid` is 0, `pred_spec` and `pred_taken` are 0.
- R3: `pred_spec` is 1 exactly when the entry's confidence is 6 or more.
- R4: `pred_taken` is 1 exactly when the entry's direction counter is 2 or 3. This holds whether or not `pred_spec` is 1.
- R5: Every update moves the direction counter one step toward the actual outcome (`upd_taken`=1 counts up, 0 counts down), saturating at 0 and 3. This happens whether `upd_spec` is 0 or 1.
- R6: An update with `upd_hit`=1 raises confidence by one, saturating at 7.
- R7: An update with `upd_hit`=0 clears confidence to 0, whatever the value of `upd_spec`.
- R8: `restart` is 1 for the one cycle after an update with `upd_spec`=1 and `upd_hit`=0, and 0 in every other cycle.
- R9: When a lookup and an update hit the same entry in the same cycle, the lookup returns the entry as it was before that update.
- R10: The entry index is an XOR fold of the PC: index bit k is the XOR of all PC bits j with j mod 7 = k. PCs with equal folds share an entry. PCs with different folds train independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | PC of the select being looked up |
| upd_valid | input | 1 | Training update |
| upd_pc | input | 32 | PC of the resolved select |
| upd_taken | input | 1 | Resolved condition outcome |
| upd_spec | input | 1 | The select was executed speculatively |
| upd_hit | input | 1 | The direction guess matched the outcome |
| pred_valid | output | 1 | Lookup result valid (one cycle after request) |
| pred_spec | output | 1 | Speculate on `pred_taken`; when 0, wait for flags |
| pred_taken | output | 1 | Predicted condition outcome |
| restart | output | 1 | One-cycle pulse: discard younger work and restart at the select |

## Verification
A lookup verdict is due in the cycle after the request. A restart pulse is due in the cycle after the update that caused it. The driver applies each cycle's stimulus on the falling edge. It pushes one expected record per cycle, computed from a reference pair of counters for every entry, with the lookup taken from the counters as they stood before that cycle's update. The monitor pops one record just after each rising edge and compares all four outputs. Because every record is tied to exactly one driven cycle, each result is checked in exactly the cycle it is due.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int DIR_W  = 2;
    localparam int CONF_W = 3;

    localparam logic [DIR_W-1:0]  DIR_MAX  = '1;
    localparam logic [CONF_W-1:0] CONF_MAX = '1;
    localparam logic [DIR_W-1:0]  DIR_INIT = DIR_W'(1);

    typedef struct packed {
        logic [DIR_W-1:0]  dir;
        logic [CONF_W-1:0] conf;
    } csel_ent_t;

    localparam csel_ent_t ENT_RESET = '{dir: DIR_INIT, conf: '0};

    typedef struct packed {
        logic taken;
        logic hit;
    } csel_train_t;

    function automatic logic [DIR_W-1:0] dir_step(input logic [DIR_W-1:0] d, input logic taken);
        if (taken)
            return (d == DIR_MAX) ? d : d + 1'b1;
        else
            return (d == '0) ? d : d - 1'b1;
    endfunction

    function automatic logic [CONF_W-1:0] conf_step(input logic [CONF_W-1:0] c, input logic hit);
        if (!hit)
            return '0;
        return (c == CONF_MAX) ? c : c + 1'b1;
    endfunction

    function automatic logic dir_guess(input logic [DIR_W-1:0] d);
        return d[DIR_W-1];
    endfunction

endpackage

// File: rtl/csel_index.sv
module csel_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 7
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int j = 0; j < PC_W; j++) begin
            idx[j % IDX_W] = idx[j % IDX_W] ^ pc[j];
        end
    end
endmodule

// File: rtl/csel_train.sv
module csel_train
    import csel_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  csel_ent_t   cur,
    input  csel_train_t trn,
    output csel_ent_t   nxt
);
    always_comb begin
        nxt.dir  = dir_step(cur.dir, trn.taken);
        nxt.conf = conf_step(cur.conf, trn.hit);
    end

    a_r6_conf_climbs: assert property (@(posedge clk) disable iff (rst)
        (en && trn.hit) |-> (nxt.conf == CONF_MAX || nxt.conf == cur.conf + 1'b1));

    a_r7_conf_clears: assert property (@(posedge clk) disable iff (rst)
        (en && !trn.hit) |-> (nxt.conf == '0));

    a_r5_dir_toward_outcome: assert property (@(posedge clk) disable iff (rst)
        en |-> (trn.taken ? (nxt.dir >= cur.dir) : (nxt.dir <= cur.dir)));
endmodule

// File: rtl/csel_table.sv
module csel_table
    import csel_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output csel_ent_t        rd_q,
    input  logic [IDX_W-1:0] upd_idx,
    output csel_ent_t        upd_cur,
    input  logic             wr_en,
    input  csel_ent_t        wr_data
);
    localparam int DEPTH = 1 << IDX_W;

    csel_ent_t mem [DEPTH];

    assign upd_cur = mem[upd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ENT_RESET;
            rd_q <= ENT_RESET;
        end else begin
            if (rd_en) rd_q <= mem[rd_idx];
            if (wr_en) mem[upd_idx] <= wr_data;
        end
    end

    a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst)) |-> (mem[$past(upd_idx)] == $past(wr_data)));

    a_r9_read_old: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && !$past(rst)) |-> (rd_q == $past(mem[rd_idx])));
endmodule

// File: rtl/csel_gate_pred.sv
module csel_gate_pred
    import csel_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int IDX_W       = 7,
    parameter int CONF_THRESH = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_spec,
    input  logic            upd_hit,
    output logic            pred_valid,
    output logic            pred_spec,
    output logic            pred_taken,
    output logic            restart
);
    localparam logic [CONF_W-1:0] THRESH = CONF_W'(CONF_THRESH);

    logic [IDX_W-1:0] lk_idx, upd_idx;
    csel_ent_t        rd_q, upd_cur, upd_nxt;
    csel_train_t      trn;
    logic             valid_q, restart_q;

    csel_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_idx  (.pc(lk_pc),  .idx(lk_idx));
    csel_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_upd_idx (.pc(upd_pc), .idx(upd_idx));

    assign trn = '{taken: upd_taken, hit: upd_hit};

    csel_table #(.IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (lk_valid),
        .rd_idx  (lk_idx),
        .rd_q    (rd_q),
        .upd_idx (upd_idx),
        .upd_cur (upd_cur),
        .wr_en   (upd_valid),
        .wr_data (upd_nxt)
    );

    csel_train u_train (
        .clk (clk),
        .rst (rst),
        .en  (upd_valid),
        .cur (upd_cur),
        .trn (trn),
        .nxt (upd_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            valid_q   <= lk_valid;
            restart_q <= upd_valid && upd_spec && !upd_hit;
        end
    end

    assign pred_valid = valid_q;
    assign pred_spec  = valid_q && (rd_q.conf >= THRESH);
    assign pred_taken = valid_q && dir_guess(rd_q.dir);
    assign restart    = restart_q;

    a_r8_restart_cause: assert property (@(posedge clk) disable iff (rst)
        restart |-> $past(upd_valid && upd_spec && !upd_hit));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lk_valid)) |-> pred_valid);

    a_r2_quiet_outputs: assert property (@(posedge clk) disable iff (rst)
        !pred_valid |-> (!pred_spec && !pred_taken));
endmodule

// File: tb/csel_gate_pred_tb.sv
module csel_gate_pred_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W  = 32;
    localparam int IDX_W = 7;
    localparam int DEPTH = 1 << IDX_W;

    typedef struct {
        bit    v;
        bit    spec;
        bit    taken;
        bit    rs;
        string tag;
    } exp_t;

    logic clk = 0, rst = 1;
    logic lk_valid = 0, upd_valid = 0, upd_taken = 0, upd_spec = 0, upd_hit = 0;
    logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
    logic pred_valid, pred_spec, pred_taken, restart;

    int total = 0, bad = 0;
    bit armed = 0, done = 0;
    exp_t q[$];
    int m_dir[DEPTH];
    int m_conf[DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    csel_gate_pred u_dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_pc(lk_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_spec(upd_spec), .upd_hit(upd_hit),
        .pred_valid(pred_valid), .pred_spec(pred_spec),
        .pred_taken(pred_taken), .restart(restart)
    );

    function automatic int fold(input logic [PC_W-1:0] pc);
        logic [IDX_W-1:0] r = '0;
        for (int j = 0; j < PC_W; j++) r[j % IDX_W] ^= pc[j];
        return int'(r);
    endfunction

    task automatic step(input bit lv, input logic [PC_W-1:0] lpc,
                        input bit uv, input logic [PC_W-1:0] upc,
                        input bit utk, input bit usp, input bit uhit, input string tag);
        exp_t e;
        int li, ui;
        @(negedge clk);
        lk_valid = lv; lk_pc = lpc;
        upd_valid = uv; upd_pc = upc; upd_taken = utk; upd_spec = usp; upd_hit = uhit;
        li = fold(lpc); ui = fold(upc);
        e.v = lv;
        e.spec = lv && (m_conf[li] >= 6);
        e.taken = lv && (m_dir[li] >= 2);
        e.rs = uv && usp && !uhit;
        e.tag = tag;
        q.push_back(e);
        if (uv) begin
            if (utk) m_dir[ui] = (m_dir[ui] == 3) ? 3 : m_dir[ui] + 1;
            else     m_dir[ui] = (m_dir[ui] == 0) ? 0 : m_dir[ui] - 1;
            m_conf[ui] = uhit ? ((m_conf[ui] == 7) ? 7 : m_conf[ui] + 1) : 0;
        end
    endtask

    task automatic look(input logic [PC_W-1:0] pc, input string tag);
        step(1, pc, 0, '0, 0, 0, 0, tag);
    endtask

    task automatic train(input logic [PC_W-1:0] pc, input bit tk, input bit sp,
                         input bit hit, input string tag);
        step(0, '0, 1, pc, tk, sp, hit, tag);
    endtask

    task automatic idle(input string tag);
        step(0, '0, 0, '0, 0, 0, 0, tag);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (armed) begin
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (pred_valid !== e.v || pred_spec !== e.spec ||
                    pred_taken !== e.taken || restart !== e.rs) begin
                    bad++;
                    $display("FAIL %s: got v=%b spec=%b taken=%b restart=%b exp v=%b spec=%b taken=%b restart=%b",
                             e.tag, pred_valid, pred_spec, pred_taken, restart,
                             e.v, e.spec, e.taken, e.rs);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog: got timeout exp completion");
        summary();
    end

    localparam logic [PC_W-1:0] PA = 32'h0000_0100;
    localparam logic [PC_W-1:0] PB = PA ^ 32'h0000_0081; // bits 0 and 7 fold together
    localparam logic [PC_W-1:0] PC = 32'h0000_0104;
    localparam logic [PC_W-1:0] PD = 32'h0000_0200;
    localparam logic [PC_W-1:0] PE = 32'h0000_0300;
    localparam logic [PC_W-1:0] PF = 32'h0000_0010;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_dir[i] = 1; m_conf[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        total++;
        if (pred_valid !== 0 || restart !== 0 || pred_spec !== 0) begin
            bad++;
            $display("FAIL R1 reset: got v=%b spec=%b restart=%b exp 0 0 0",
                     pred_valid, pred_spec, restart);
        end
        armed = 1;

        look(PA, "R1 fresh entry");
        idle("R2 no lookup");
        for (int i = 0; i < 5; i++) train(PA, 1, 0, 1, "R6 climb");
        look(PA, "R3 conf5 no spec");
        train(PA, 1, 0, 1, "R6 climb");
        look(PA, "R3 conf6 speculate");
        look(PB, "R10 alias shares entry");
        look(PC, "R10 distinct entry");

        train(PA, 0, 1, 0, "R8 spec miss restart");
        look(PA, "R7 cleared after spec miss");
        train(PA, 0, 0, 0, "R8 unspec miss no restart");
        look(PA, "R5 dir down unspec");
        train(PA, 0, 1, 0, "R8 first miss");
        train(PA, 0, 1, 0, "R8 back-to-back miss");
        idle("R8 pulse ends");

        for (int i = 0; i < 6; i++) train(PC, 1, 0, 1, "R6 climb C");
        step(1, PC, 1, PC, 0, 1, 0, "R9 same-cycle old value");
        look(PC, "R9 update visible next");

        for (int i = 0; i < 9; i++) train(PD, 1, 0, 1, "R6 saturate");
        look(PD, "R6 saturated conf still spec");

        for (int i = 0; i < 5; i++) train(PE, 1, 0, 1, "R5 saturate up");
        train(PE, 0, 0, 1, "R5 one down");
        look(PE, "R5 saturated dir still taken");

        for (int i = 0; i < 3; i++) train(PF, 0, 0, 1, "R5 down");
        look(PF, "R4 not-taken guess");
        for (int i = 0; i < 3; i++) train(PF, 0, 0, 1, "R6 climb F");
        look(PF, "R4 spec with not-taken");

        idle("drain");
        idle("drain");
        @(negedge clk);
        summary();
    end
endmodule